// File: doc/BRIEF.md
# Power Control Special Function Register

This block is the byte-wide power control register of an 8051-style microcontroller core. It sits on the core's internal special function register bus at direct address 87h. Software uses it to request idle or powerdown mode and to double the serial baud rate. It also chooses which storage bit answers at bit 7 of the serial control register: the framing-error flag or the serial mode bit. The register also holds two scratch flags for software, and a power-off flag that the supply detector raises.

The two mode requests are registered. They clear themselves when the core takes an interrupt. If both are set, powerdown wins, so only one request reaches the clock controller. The power-off flag is not touched by an ordinary reset. Software can read it after reset to tell a cold start from a warm one. The serial bit-7 steering is combinational and uses the current select bit. The serial port keeps both storage bits and takes the write enables and read value from here.

Top module: `pwr_ctl_sfr`

## Requirements
- R1: A write with `sfr_wr` high and `sfr_addr` equal to 87h updates the register at the next clock edge; a write to any other address leaves it unchanged. While `sfr_addr` is 87h, `sfr_rdata` shows the register as {baud-double (bit 7), steer-select (bit 6), reserved (bit 5), power-off (bit 4), flag 1 (bit 3), flag 0 (bit 2), powerdown (bit 1), idle (bit 0)}; at any other address `sfr_rdata` is 00h.
- R2: A synchronous reset (`rst_n` low at a clock edge) clears bits 7:6 and 3:0 and leaves the power-off flag (bit 4) unchanged.
- R3: The reserved bit 5 ignores writes and always reads 0.
- R4: An `irq_taken` pulse clears the powerdown and idle bits at the next edge, and it wins over a write to them in the same cycle.
- R5: When both the powerdown and idle bits are set, `pdown_req` is 1 and `idle_req` is 0.
- R6: `idle_req` and `pdown_req` take a value that was written in the cycle after the write edge, and not before it.
- R7: A `pwr_up` pulse sets the power-off flag at the next edge and wins over a write of 0 to it in the same cycle. Otherwise software sets or clears the flag by writing bit 4.
- R8: `scon7_rdata` equals `fe_in` when the steer-select bit is 1 and `sm0_in` when it is 0.
- R9: A `scon_wr` strobe drives `fe_we` alone when the steer-select bit is 1, and `sm0_we` alone when it is 0.
- R10: `baud_dbl` follows the stored baud-double bit (bit 7).
- R11: Flags 1 and 0 (bits 3 and 2) hold whatever software writes, and they affect no output other than `sfr_rdata`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sfr_addr | input | 8 | Register bus direct address |
| sfr_wr | input | 1 | Register bus write strobe |
| sfr_wdata | input | 8 | Register bus write data |
| sfr_rdata | output | 8 | Read data, 00h when the address does not match |
| irq_taken | input | 1 | One-cycle pulse when an interrupt is taken |
| pwr_up | input | 1 | Pulse from the supply detector on a power-good rise |
| idle_req | output | 1 | Idle mode request |
| pdown_req | output | 1 | Powerdown mode request |
| baud_dbl | output | 1 | Serial baud-rate doubling control |
| scon_wr | input | 1 | Write strobe for the serial control register |
| fe_in | input | 1 | Framing-error flag from the serial port |
| sm0_in | input | 1 | Mode bit 0 from the serial port |
| scon7_rdata | output | 1 | Value returned at serial control bit 7 |
| fe_we | output | 1 | Write enable for the framing-error flag |
| sm0_we | output | 1 | Write enable for the mode bit 0 |

## Verification
The hardest cases to reach are the same-cycle collisions. One is a software write that sets a mode bit in the very cycle an interrupt is taken. The other is a write that clears the power-off flag in the very cycle the supply detector pulses. The bench drives both strobes at the same negative edge, so they are sampled together at one rising edge, and then reads the register back. The bench also sets the power-off flag and then applies reset, to show that the flag survives a reset that clears every other bit.

// File: rtl/pwrctl_pkg.sv
// Package pwrctl_pkg
// Shared constants for the power control register. The bit positions are
// fixed because software decodes them; the address is the default decode.
package pwrctl_pkg;
    localparam int unsigned PC_DATA_W   = 8;
    localparam int unsigned PC_ADDR_W   = 8;
    localparam int unsigned BIT_IDL     = 0;
    localparam int unsigned BIT_PD      = 1;
    localparam int unsigned BIT_GF_LO   = 2;
    localparam int unsigned BIT_POF     = 4;
    localparam int unsigned BIT_RSV     = 5;
    localparam int unsigned BIT_SEL     = 6;
    localparam int unsigned BIT_BAUD    = 7;
    localparam int unsigned NUM_GPF     = 2;

    typedef struct packed {
        logic                baud;
        logic                sel;
        logic                pof;
        logic [NUM_GPF-1:0]  gpf;
        logic                pd;
        logic                idl;
    } pwr_fields_t;
endpackage

// File: rtl/pwr_mode_ctl.sv
// Module pwr_mode_ctl
// Holds the powerdown and idle request bits. A taken interrupt or a reset
// clears both, and the clear beats a software write in the same cycle. The
// request outputs are registered from the next-state values, with powerdown
// masking idle.
// Assumes: irq_taken is a single-cycle pulse synchronous to clk.
module pwr_mode_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_hit,
    input  logic wr_pd,
    input  logic wr_idl,
    input  logic irq_taken,
    output logic pd_q,
    output logic idl_q,
    output logic idle_req,
    output logic pdown_req
);
    logic pd_d;
    logic idl_d;

    // Next state: the hardware clear wins, then the software write, else hold.
    always_comb begin
        pd_d  = pd_q;
        idl_d = idl_q;
        if (irq_taken) begin
            pd_d  = 1'b0;
            idl_d = 1'b0;
        end else if (wr_hit) begin
            pd_d  = wr_pd;
            idl_d = wr_idl;
        end
    end

    // Mode bit storage and registered requests, with powerdown taking precedence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pd_q      <= 1'b0;
            idl_q     <= 1'b0;
            pdown_req <= 1'b0;
            idle_req  <= 1'b0;
        end else begin
            pd_q      <= pd_d;
            idl_q     <= idl_d;
            pdown_req <= pd_d;
            idle_req  <= idl_d & ~pd_d;
        end
    end
endmodule

// File: rtl/pwr_flag_regs.sv
// Module pwr_flag_regs
// Holds the baud-double bit, the steer-select bit, the general flags and the
// power-off flag. The power-off flag has no reset: only the supply detector
// pulse (which has priority) or a software write changes it.
// Assumes: pwr_up is a single-cycle pulse synchronous to clk.
module pwr_flag_regs #(
    parameter int unsigned NUM_GPF = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_hit,
    input  logic               wr_baud,
    input  logic               wr_sel,
    input  logic               wr_pof,
    input  logic [NUM_GPF-1:0] wr_gpf,
    input  logic               pwr_up,
    output logic               baud_q,
    output logic               sel_q,
    output logic               pof_q,
    output logic [NUM_GPF-1:0] gpf_q
);
    // Serial control bits: cleared by reset, loaded by a matching write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            baud_q <= 1'b0;
            sel_q  <= 1'b0;
        end else if (wr_hit) begin
            baud_q <= wr_baud;
            sel_q  <= wr_sel;
        end
    end

    // One plain storage flop for each general-purpose flag.
    for (genvar g = 0; g < NUM_GPF; g++) begin : g_gpf
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                gpf_q[g] <= 1'b0;
            end else if (wr_hit) begin
                gpf_q[g] <= wr_gpf[g];
            end
        end
    end

    // Power-off flag: the detector pulse wins, and reset does not touch it.
    always_ff @(posedge clk) begin
        if (pwr_up) begin
            pof_q <= 1'b1;
        end else if (wr_hit) begin
            pof_q <= wr_pof;
        end
    end
endmodule

// File: rtl/ser_bit7_steer.sv
// Module ser_bit7_steer
// Routes accesses at serial control bit 7 to either the framing-error flag
// or the mode bit 0, using the current steer-select value. Purely
// combinational; both storage bits stay in the serial port.
module ser_bit7_steer (
    input  logic sel,
    input  logic scon_wr,
    input  logic fe_in,
    input  logic sm0_in,
    output logic rdata,
    output logic fe_we,
    output logic sm0_we
);
    // Read mux and the split write enables.
    always_comb begin
        rdata  = sel ? fe_in : sm0_in;
        fe_we  = scon_wr & sel;
        sm0_we = scon_wr & ~sel;
    end
endmodule

// File: rtl/pwr_ctl_sfr.sv
// Module pwr_ctl_sfr
// Top of the power control register. It decodes the register bus address,
// assembles the read byte (the reserved bit reads 0), and ties together the
// mode, flag and serial steering submodules.
// Assumes: bus strobes and pulses are synchronous to clk; reset is
// synchronous and active low.
module pwr_ctl_sfr #(
    parameter logic [7:0] SFR_ADDR = 8'h87
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] sfr_addr,
    input  logic       sfr_wr,
    input  logic [7:0] sfr_wdata,
    output logic [7:0] sfr_rdata,
    input  logic       irq_taken,
    input  logic       pwr_up,
    output logic       idle_req,
    output logic       pdown_req,
    output logic       baud_dbl,
    input  logic       scon_wr,
    input  logic       fe_in,
    input  logic       sm0_in,
    output logic       scon7_rdata,
    output logic       fe_we,
    output logic       sm0_we
);
    import pwrctl_pkg::*;

    localparam int unsigned GPF_HI = BIT_GF_LO + NUM_GPF - 1;

    logic        addr_hit;
    logic        wr_hit;
    pwr_fields_t fld;

    // Address decode for reads and writes.
    always_comb begin
        addr_hit = (sfr_addr == SFR_ADDR);
        wr_hit   = addr_hit & sfr_wr;
    end

    pwr_mode_ctl u_mode (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_hit    (wr_hit),
        .wr_pd     (sfr_wdata[BIT_PD]),
        .wr_idl    (sfr_wdata[BIT_IDL]),
        .irq_taken (irq_taken),
        .pd_q      (fld.pd),
        .idl_q     (fld.idl),
        .idle_req  (idle_req),
        .pdown_req (pdown_req)
    );

    pwr_flag_regs #(
        .NUM_GPF (NUM_GPF)
    ) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_hit  (wr_hit),
        .wr_baud (sfr_wdata[BIT_BAUD]),
        .wr_sel  (sfr_wdata[BIT_SEL]),
        .wr_pof  (sfr_wdata[BIT_POF]),
        .wr_gpf  (sfr_wdata[GPF_HI:BIT_GF_LO]),
        .pwr_up  (pwr_up),
        .baud_q  (fld.baud),
        .sel_q   (fld.sel),
        .pof_q   (fld.pof),
        .gpf_q   (fld.gpf)
    );

    ser_bit7_steer u_steer (
        .sel     (fld.sel),
        .scon_wr (scon_wr),
        .fe_in   (fe_in),
        .sm0_in  (sm0_in),
        .rdata   (scon7_rdata),
        .fe_we   (fe_we),
        .sm0_we  (sm0_we)
    );

    // Read byte assembly; zero when the address does not match.
    always_comb begin
        sfr_rdata = '0;
        if (addr_hit) begin
            sfr_rdata[BIT_BAUD]          = fld.baud;
            sfr_rdata[BIT_SEL]           = fld.sel;
            sfr_rdata[BIT_RSV]           = 1'b0;
            sfr_rdata[BIT_POF]           = fld.pof;
            sfr_rdata[GPF_HI:BIT_GF_LO]  = fld.gpf;
            sfr_rdata[BIT_PD]            = fld.pd;
            sfr_rdata[BIT_IDL]           = fld.idl;
        end
    end

    // Baud-double output straight from storage.
    always_comb baud_dbl = fld.baud;
endmodule

// File: rtl/pwr_ctl_sfr_chk.sv
// Module pwr_ctl_sfr_chk
// Checker bound to pwr_ctl_sfr. It watches only the ports and checks the
// timing relations between the mode requests, interrupts, writes and the
// power-off flag.
module pwr_ctl_sfr_chk #(
    parameter logic [7:0] SFR_ADDR = 8'h87
) (
    input logic       clk,
    input logic       rst_n,
    input logic [7:0] sfr_addr,
    input logic       sfr_wr,
    input logic [7:0] sfr_wdata,
    input logic [7:0] sfr_rdata,
    input logic       irq_taken,
    input logic       pwr_up,
    input logic       idle_req,
    input logic       pdown_req,
    input logic       baud_dbl
);
    // R5: powerdown masks idle.
    p_pd_over_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pdown_req |-> !idle_req);

    // R4: a taken interrupt drops both requests at the next edge.
    p_irq_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        irq_taken |=> (!idle_req && !pdown_req));

    // R6: a write with no interrupt shows on the requests one edge later.
    p_wr_to_req_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (sfr_wr && sfr_addr == SFR_ADDR && !irq_taken) |=>
            (pdown_req == $past(sfr_wdata[1]) &&
             idle_req == ($past(sfr_wdata[0]) && !$past(sfr_wdata[1]))));

    // R7: a detector pulse leaves the power-off flag set.
    p_pof_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_up |=> (sfr_addr != SFR_ADDR || sfr_rdata[4]));

    // R10: baud doubling changes only through a matching write.
    p_baud_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(sfr_wr && sfr_addr == SFR_ADDR) |=> $stable(baud_dbl));

    // R3: the reserved bit always reads zero.
    p_rsv_zero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        sfr_rdata[5] == 1'b0);
endmodule

bind pwr_ctl_sfr pwr_ctl_sfr_chk #(.SFR_ADDR(SFR_ADDR)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .sfr_addr  (sfr_addr),
    .sfr_wr    (sfr_wr),
    .sfr_wdata (sfr_wdata),
    .sfr_rdata (sfr_rdata),
    .irq_taken (irq_taken),
    .pwr_up    (pwr_up),
    .idle_req  (idle_req),
    .pdown_req (pdown_req),
    .baud_dbl  (baud_dbl)
);

// File: tb/pwr_ctl_sfr_tb_top.sv
// Directed bench for pwr_ctl_sfr: one task for each scenario, and each task
// checks its own results. Inputs change at the negative edge; outputs are
// sampled at the negative edge, after the rising edge that updates them.
module pwr_ctl_sfr_tb_top;
    localparam logic [7:0] A_PC = 8'h87;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] sfr_addr = 8'h00;
    logic       sfr_wr = 1'b0;
    logic [7:0] sfr_wdata = 8'h00;
    logic [7:0] sfr_rdata;
    logic       irq_taken = 1'b0;
    logic       pwr_up = 1'b0;
    logic       idle_req, pdown_req, baud_dbl;
    logic       scon_wr = 1'b0, fe_in = 1'b0, sm0_in = 1'b0;
    logic       scon7_rdata, fe_we, sm0_we;

    int total = 0;
    int bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    pwr_ctl_sfr dut_i (
        .clk(clk), .rst_n(rst_n), .sfr_addr(sfr_addr), .sfr_wr(sfr_wr),
        .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata), .irq_taken(irq_taken),
        .pwr_up(pwr_up), .idle_req(idle_req), .pdown_req(pdown_req),
        .baud_dbl(baud_dbl), .scon_wr(scon_wr), .fe_in(fe_in),
        .sm0_in(sm0_in), .scon7_rdata(scon7_rdata), .fe_we(fe_we),
        .sm0_we(sm0_we)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    // Write one byte; returns at the negedge after the write edge.
    task automatic bus_wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        sfr_addr = a; sfr_wr = 1'b1; sfr_wdata = d;
        @(negedge clk);
        sfr_wr = 1'b0;
    endtask

    task automatic bus_rd(input logic [7:0] a, output logic [7:0] d);
        sfr_addr = a;
        #1;
        d = sfr_rdata;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rst_n = 1'b0; pwr_up = 1'b1;
        repeat (3) @(negedge clk);
        pwr_up = 1'b0; rst_n = 1'b1;
        @(negedge clk);
        bus_rd(A_PC, d);
        chk("R2 reset value", d, 8'h10);
        chk("R5 outputs after reset", {6'd0, idle_req, pdown_req}, 8'h00);
    endtask

    task automatic t_decode();
        logic [7:0] d;
        bus_wr(8'h86, 8'hCF);
        bus_rd(A_PC, d);
        chk("R1 other address write ignored", d, 8'h10);
        bus_rd(8'h86, d);
        chk("R1 other address reads zero", d, 8'h00);
        bus_wr(A_PC, 8'h1C);
        bus_rd(A_PC, d);
        chk("R11 flags stored", d, 8'h1C);
        chk("R11 flags no side effect", {5'd0, baud_dbl, idle_req, pdown_req}, 8'h00);
    endtask

    task automatic t_reserved_pof();
        logic [7:0] d;
        bus_wr(A_PC, 8'h30);
        bus_rd(A_PC, d);
        chk("R3 reserved reads zero", d, 8'h10);
        bus_wr(A_PC, 8'h00);
        bus_rd(A_PC, d);
        chk("R7 software clear", d, 8'h00);
        @(negedge clk);
        sfr_addr = A_PC; sfr_wr = 1'b1; sfr_wdata = 8'h00; pwr_up = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0; pwr_up = 1'b0;
        bus_rd(A_PC, d);
        chk("R7 detector beats write", d, 8'h10);
    endtask

    task automatic t_reset_keeps_pof();
        logic [7:0] d;
        bus_wr(A_PC, 8'hDF);
        bus_rd(A_PC, d);
        chk("R1 full write", d, 8'hDF);
        chk("R5 both set", {6'd0, idle_req, pdown_req}, 8'h01);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_rd(A_PC, d);
        chk("R2 reset keeps power-off set", d, 8'h10);
        bus_wr(A_PC, 8'h00);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        bus_rd(A_PC, d);
        chk("R2 reset keeps power-off clear", d, 8'h00);
    endtask

    task automatic t_modes();
        @(negedge clk);
        sfr_addr = A_PC; sfr_wr = 1'b1; sfr_wdata = 8'h01;
        #1;
        chk("R6 idle not early", {7'd0, idle_req}, 8'h00);
        @(negedge clk);
        sfr_wr = 1'b0;
        chk("R6 idle next cycle", {6'd0, idle_req, pdown_req}, 8'h02);
        bus_wr(A_PC, 8'h03);
        chk("R5 powerdown wins", {6'd0, idle_req, pdown_req}, 8'h01);
    endtask

    task automatic t_irq();
        logic [7:0] d;
        bus_wr(A_PC, 8'h0D);
        @(negedge clk); irq_taken = 1'b1;
        @(negedge clk); irq_taken = 1'b0;
        bus_rd(A_PC, d);
        chk("R4 interrupt clears modes", d, 8'h0C);
        chk("R4 requests dropped", {6'd0, idle_req, pdown_req}, 8'h00);
        @(negedge clk);
        sfr_addr = A_PC; sfr_wr = 1'b1; sfr_wdata = 8'h02; irq_taken = 1'b1;
        @(negedge clk);
        sfr_wr = 1'b0; irq_taken = 1'b0;
        bus_rd(A_PC, d);
        chk("R4 clear beats write", d, 8'h00);
        chk("R4 no powerdown", {7'd0, pdown_req}, 8'h00);
    endtask

    task automatic t_steer();
        bus_wr(A_PC, 8'h40);
        fe_in = 1'b1; sm0_in = 1'b0; scon_wr = 1'b1;
        #1;
        chk("R8 select fe", {7'd0, scon7_rdata}, 8'h01);
        chk("R9 fe enable", {6'd0, fe_we, sm0_we}, 8'h02);
        scon_wr = 1'b0;
        bus_wr(A_PC, 8'h00);
        scon_wr = 1'b1;
        #1;
        chk("R8 select sm0", {7'd0, scon7_rdata}, 8'h00);
        chk("R9 sm0 enable", {6'd0, fe_we, sm0_we}, 8'h01);
        scon_wr = 1'b0;
        bus_wr(A_PC, 8'h80);
        chk("R10 baud double on", {7'd0, baud_dbl}, 8'h01);
        bus_wr(A_PC, 8'h00);
        chk("R10 baud double off", {7'd0, baud_dbl}, 8'h00);
    endtask

    initial begin
        t_reset();
        t_decode();
        t_reserved_pof();
        t_reset_keeps_pof();
        t_modes();
        t_irq();
        t_steer();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++; bad++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule